// File: doc/BRIEF.md
# Four-Point Cubic Interpolator

This block estimates a sample value between two neighbours of a uniformly sampled signal. It receives four consecutive signed samples, placed at times -1, 0, 1 and 2 on a unit grid, together with an unsigned fractional position `mu` in Q0.F form. It returns the value at time `mu` of the single cubic polynomial that passes through all four points. That result lies between the second and third samples.

The four polynomial coefficients come from fixed closed-form sums of the samples. Those sums are built only from shifts and additions. The cubic is then evaluated in nested form, with one multiply by `mu` in each of three pipeline stages. Each product is rounded to nearest before the next coefficient is added. The nested sum carries an overall factor of six, and a final stage removes it by multiplying by 1/6. That multiply is a truncated sum of shifted copies, because 1/6 is 0.0010101... in binary.

The pipeline accepts a new sample set on every clock cycle. Each result appears a fixed number of cycles later, marked by an output valid strobe.

Top module: `cubic_interp`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly 5 clock cycles earlier. A new sample set is accepted on every cycle, with or without idle cycles in between.
- R2: The value of `y_out` never differs by more than one output LSB from the exact value of the cubic through (-1,y0), (0,y1), (1,y2), (2,y3) at t = mu_code / 2^FW.
- R3: Full-scale inputs never overflow an internal stage and still meet the R2 accuracy. This includes alternating-sign patterns such as -32768, 32767, -32768, 32767 for 16-bit samples.
- R4: When `mu` is 0, `y_out` equals `y1` exactly.
- R5: When all four samples are equal, `y_out` equals that sample exactly for any `mu`.
- R6: While `rst` is high, and for the 5 cycles after it falls with `in_valid` held low, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Marks a sample set and position to process |
| y0 | input | SW | Sample at t = -1, signed |
| y1 | input | SW | Sample at t = 0, signed |
| y2 | input | SW | Sample at t = 1, signed |
| y3 | input | SW | Sample at t = 2, signed |
| mu | input | FW | Fractional position, unsigned Q0.FW |
| out_valid | output | 1 | Marks a valid result on `y_out` |
| y_out | output | SW+2 | Interpolated value, signed, same LSB as the samples |

## Verification
Random sample sets with random positions exercise general accuracy against an exact rational evaluation of the cubic in Lagrange form. This evaluation shares no arithmetic with the design, so any error in a coefficient or a rounding step shows up. The same runs use streams with idle cycles mixed in; these expose latency or valid-alignment faults that a continuous stream would hide. Zero positions and constant sample sets must give exact results, so they catch any bias in the 1/6 scaling or in the rounding. Full-scale alternating-sign sets push the coefficients to their largest magnitudes, which separates correct guard widths from ones that wrap.

// File: rtl/cubic_interp_pkg.sv
package cubic_interp_pkg;

    // cycles from in_valid to out_valid
    localparam int PIPE_DEPTH = 5;

    // number of shifted terms in the 1/6 expansion for a given sample width
    function automatic int sixth_terms(input int sw);
        return sw / 2 + 3;
    endfunction

    // extra fractional bits kept while summing the expansion
    function automatic int sixth_guard(input int nt);
        return $clog2(nt) + 4;
    endfunction

endpackage

// File: rtl/cubic_coef.sv
module cubic_coef #(
    parameter int SW = 16,
    parameter int CW = SW + 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  logic signed [SW-1:0] s0,
    input  logic signed [SW-1:0] s1,
    input  logic signed [SW-1:0] s2,
    input  logic signed [SW-1:0] s3,
    output logic                 v_out,
    output logic signed [CW-1:0] k3,
    output logic signed [CW-1:0] k2,
    output logic signed [CW-1:0] k1,
    output logic signed [CW-1:0] k0
);
    logic signed [CW-1:0] e0, e1, e2, e3, dif12, sum02, six1, n3, n2, n1;

    always_comb begin
        e0    = CW'(s0);
        e1    = CW'(s1);
        e2    = CW'(s2);
        e3    = CW'(s3);
        dif12 = e1 - e2;
        sum02 = e0 + e2;
        six1  = (e1 <<< 2) + (e1 <<< 1);
        n3    = e3 - e0 + (dif12 <<< 1) + dif12;
        n2    = (sum02 <<< 1) + sum02 - six1;
        n1    = (e2 <<< 2) + (e2 <<< 1) - (e0 <<< 1) - ((e1 <<< 1) + e1) - e3;
    end

    always_ff @(posedge clk) begin
        if (rst) v_out <= 1'b0;
        else     v_out <= v_in;
        k3 <= n3;
        k2 <= n2;
        k1 <= n1;
        k0 <= six1;
    end

    // R2: the coefficients reproduce six times the samples at t = 1 and t = -1
    p_coef_fit_r2: assert property (@(posedge clk) disable iff (rst)
        (k3 + k2 + k1 + k0) == 6 * $past(s2));
    p_coef_back_r2: assert property (@(posedge clk) disable iff (rst)
        (k2 + k0 - k3 - k1) == 6 * $past(s0));
endmodule

// File: rtl/cubic_horner_step.sv
module cubic_horner_step #(
    parameter int AW = 23,
    parameter int FW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  logic signed [AW-1:0] acc_in,
    input  logic signed [AW-1:0] add_in,
    input  logic        [FW-1:0] mu_in,
    output logic                 v_out,
    output logic signed [AW-1:0] acc_out
);
    localparam int PW = AW + FW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (FW - 1);

    logic signed [PW-1:0] prod, rnd, wide;

    always_comb begin
        prod = PW'(acc_in) * PW'($signed({1'b0, mu_in}));
        rnd  = (prod + HALF) >>> FW;
        wide = rnd + PW'(add_in);
    end

    always_ff @(posedge clk) begin
        if (rst) v_out <= 1'b0;
        else     v_out <= v_in;
        acc_out <= AW'(wide);
    end

    // R3: the multiply-add result fits the accumulator width
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        v_in |-> (wide == PW'($signed(AW'(wide)))));
endmodule

// File: rtl/cubic_sixth.sv
module cubic_sixth #(
    parameter int AW = 23,
    parameter int OW = 18,
    parameter int NT = 11,
    parameter int G  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 v_in,
    input  logic signed [AW-1:0] h_in,
    output logic                 v_out,
    output logic signed [OW-1:0] y_out
);
    localparam int EW = AW + G;
    localparam logic signed [EW-1:0] HALF = EW'(1) << (G - 1);

    logic signed [EW-1:0] ext, total, rnd;

    assign ext = EW'(h_in) <<< G;

    // 1/6 = sum over k of 2^-(2k+3)
    for (genvar k = 0; k < NT; k++) begin : g_term
        logic signed [EW-1:0] run;
        if (k == 0) begin : g_first
            assign run = ext >>> 3;
        end else begin : g_next
            assign run = g_term[k-1].run + (ext >>> (2 * k + 3));
        end
    end

    assign total = g_term[NT-1].run;
    assign rnd   = (total + HALF) >>> G;

    always_ff @(posedge clk) begin
        if (rst) v_out <= 1'b0;
        else     v_out <= v_in;
        y_out <= OW'(rnd);
    end

    // R2: six times the scaled value stays within rounding distance of the input
    p_scale_r2: assert property (@(posedge clk) disable iff (rst)
        v_out |-> (($signed(y_out) * 6 - $past(h_in)) <= 4 &&
                   ($signed(y_out) * 6 - $past(h_in)) >= -4));
endmodule

// File: rtl/cubic_interp.sv
module cubic_interp
    import cubic_interp_pkg::*;
#(
    parameter int SW = 16,
    parameter int FW = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic signed [SW-1:0] y0,
    input  logic signed [SW-1:0] y1,
    input  logic signed [SW-1:0] y2,
    input  logic signed [SW-1:0] y3,
    input  logic        [FW-1:0] mu,
    output logic                 out_valid,
    output logic signed [SW+1:0] y_out
);
    localparam int CW = SW + 4;
    localparam int AW = SW + 7;
    localparam int OW = SW + 2;
    localparam int NT = sixth_terms(SW);
    localparam int G  = sixth_guard(NT);

    logic                 v1, v2, v3, v4;
    logic signed [CW-1:0] ca, cb, cc, cd, cc_d, cd_d, cd_dd;
    logic        [FW-1:0] mu1, mu2, mu3;
    logic signed [AW-1:0] h1, h2, h3;

    cubic_coef #(.SW(SW), .CW(CW)) u_coef (
        .clk(clk), .rst(rst), .v_in(in_valid),
        .s0(y0), .s1(y1), .s2(y2), .s3(y3),
        .v_out(v1), .k3(ca), .k2(cb), .k1(cc), .k0(cd));

    always_ff @(posedge clk) begin
        mu1   <= mu;
        mu2   <= mu1;
        mu3   <= mu2;
        cc_d  <= cc;
        cd_d  <= cd;
        cd_dd <= cd_d;
    end

    cubic_horner_step #(.AW(AW), .FW(FW)) u_step_a (
        .clk(clk), .rst(rst), .v_in(v1), .acc_in(AW'(ca)), .add_in(AW'(cb)),
        .mu_in(mu1), .v_out(v2), .acc_out(h1));

    cubic_horner_step #(.AW(AW), .FW(FW)) u_step_b (
        .clk(clk), .rst(rst), .v_in(v2), .acc_in(h1), .add_in(AW'(cc_d)),
        .mu_in(mu2), .v_out(v3), .acc_out(h2));

    cubic_horner_step #(.AW(AW), .FW(FW)) u_step_c (
        .clk(clk), .rst(rst), .v_in(v3), .acc_in(h2), .add_in(AW'(cd_dd)),
        .mu_in(mu3), .v_out(v4), .acc_out(h3));

    cubic_sixth #(.AW(AW), .OW(OW), .NT(NT), .G(G)) u_sixth (
        .clk(clk), .rst(rst), .v_in(v4), .h_in(h3),
        .v_out(out_valid), .y_out(y_out));

    // cycles since reset, saturating, used to bound the latency check
    logic [2:0] warm;
    always_ff @(posedge clk) begin
        if (rst)                       warm <= '0;
        else if (warm != 3'(PIPE_DEPTH)) warm <= warm + 3'd1;
    end

    // R1: fixed latency from input strobe to output strobe
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        (warm == 3'(PIPE_DEPTH)) |-> (out_valid == $past(in_valid, 5)));
endmodule

// File: tb/cubic_interp_test.sv
module cubic_interp_test;
    localparam int SW = 16;
    localparam int FW = 12;
    localparam longint S = 64'sd1 << FW;
    localparam longint DEN = 6 * S * S * S;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [SW-1:0] y0 = '0, y1 = '0, y2 = '0, y3 = '0;
    logic [FW-1:0] mu = '0;
    logic out_valid;
    logic signed [SW+1:0] y_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    bit     qv[$];
    longint qnum[$];
    bit     qex[$];
    longint qexp[$];
    string  qtag[$];

    always #5 clk = ~clk;

    cubic_interp #(.SW(SW), .FW(FW)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .y0(y0), .y1(y1), .y2(y2), .y3(y3), .mu(mu),
        .out_valid(out_valid), .y_out(y_out));

    // six * S^3 times the exact cubic value, from the Lagrange basis
    function automatic longint ref_num(longint a, longint b, longint c, longint d, longint m);
        longint w0, w1, w2, w3;
        w0 = -m * (m - S) * (m - 2 * S);
        w1 = 3 * (m + S) * (m - S) * (m - 2 * S);
        w2 = -3 * (m + S) * m * (m - 2 * S);
        w3 = m * (m + S) * (m - S);
        return a * w0 + b * w1 + c * w2 + d * w3;
    endfunction

    task automatic compare_oldest();
        bit v; longint num; bit ex; longint e; string tag; longint act; longint diff;
        v = qv.pop_front(); num = qnum.pop_front(); ex = qex.pop_front();
        e = qexp.pop_front(); tag = qtag.pop_front();
        checks++;
        if (out_valid !== v) begin
            errors++;
            $display("FAIL R1 (%s): out_valid actual %0d expected %0d", tag, out_valid, v);
        end
        if (v) begin
            checks++;
            act = longint'(y_out);
            if (ex) begin
                if (act != e) begin
                    errors++;
                    $display("FAIL %s: y_out actual %0d expected %0d", tag, act, e);
                end
            end else begin
                diff = act * DEN - num;
                if (diff > DEN || diff < -DEN) begin
                    errors++;
                    $display("FAIL %s: y_out actual %0d expected about %0d", tag, act, num / DEN);
                end
            end
        end
    endtask

    task automatic cycle(input bit v, input int a, input int b, input int c, input int d,
                         input int m, input string tag, input bit ex, input int e);
        @(negedge clk);
        compare_oldest();
        in_valid = v;
        y0 = SW'(a); y1 = SW'(b); y2 = SW'(c); y3 = SW'(d); mu = FW'(m);
        qv.push_back(v);
        qnum.push_back(ref_num(a, b, c, d, m));
        qex.push_back(ex);
        qexp.push_back(longint'(e));
        qtag.push_back(tag);
    endtask

    function automatic int rs();
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        int full[4][4];
        int mus[5];
        full[0] = '{-32768, 32767, -32768, 32767};
        full[1] = '{32767, -32768, 32767, -32768};
        full[2] = '{32767, -32768, -32768, 32767};
        full[3] = '{-32768, 32767, 32767, -32768};
        mus = '{1, 1024, 2048, 3071, 4095};

        // R6: no output strobe during reset
        repeat (4) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                errors++;
                $display("FAIL R6: out_valid actual %0d expected 0", out_valid);
            end
        end
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            qv.push_back(1'b0); qnum.push_back(0); qex.push_back(1'b0);
            qexp.push_back(0); qtag.push_back("R6");
        end

        // R4: zero position returns the second sample exactly
        for (int i = 0; i < 8; i++) begin
            int a, b, c, d;
            a = rs(); b = rs(); c = rs(); d = rs();
            if (i == 0) begin a = 32767; b = -32768; c = 32767; d = -32768; end
            cycle(1'b1, a, b, c, d, 0, "R4", 1'b1, b);
        end

        // R5: constant samples for several positions
        for (int i = 0; i < 4; i++) begin
            int cv;
            cv = (i == 0) ? 0 : (i == 1) ? 1234 : (i == 2) ? -32768 : 32767;
            for (int j = 0; j < 5; j++)
                cycle(1'b1, cv, cv, cv, cv, mus[j], "R5", 1'b1, cv);
        end

        // R3: full-scale alternating and paired extremes
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 5; j++)
                cycle(1'b1, full[i][0], full[i][1], full[i][2], full[i][3],
                      mus[j], "R3", 1'b0, 0);

        // R1: idle cycles mixed into the stream
        for (int i = 0; i < 40; i++) begin
            bit v;
            v = (i % 3) != 1;
            cycle(v, rs(), rs(), rs(), rs(), int'($urandom % 4096), "R1", 1'b0, 0);
        end

        // R2: random samples and positions, including the largest position
        for (int i = 0; i < 300; i++) begin
            bit v;
            int m;
            v = ($urandom % 4) != 0;
            m = (i % 10 == 0) ? 4095 : int'($urandom % 4096);
            cycle(v, rs(), rs(), rs(), rs(), m, "R2", 1'b0, 0);
        end

        // drain
        repeat (6) cycle(1'b0, 0, 0, 0, 0, 0, "R1", 1'b0, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule